// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional odd or even parity bit, and a high stop interval of one, one and a half or two bit times. The line rests high between frames. Bit timing comes from a clock-enable input, `tx_tick`, that runs at 1, 16 or 64 times the bit rate. The rate code picks which, and each bit lasts that many ticks.

The host writes a character into a one-entry holding buffer by pulsing `ld` while `ready` is high. When the shifter is idle and both `tx_en` and `cts` are high, the buffered character moves into the shifter and `ready` rises again. The host can therefore queue the next character while the current one is still on the line. `empty` is high only when nothing is buffered and nothing is being shifted. The `brk` input holds the line low for as long as it is asserted.

Top module: `sertx_top`

## Requirements
- R1: While `rst_n` is low and right after its release, `txd` is high, `ready` is high and `empty` is high.
- R2: A frame is one low start bit, then the data bits least significant first, then the optional parity bit, then a high stop interval. Between frames `txd` is high.
- R3: `len_sel` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent.
- R4: With `par_en` high, a parity bit follows the data. With `par_even` = 1 it makes the count of ones among the data and parity bits even. With `par_even` = 0 it makes that count odd. With `par_en` low, no parity bit is sent.
- R5: Each start, data and parity bit lasts a fixed number of `tx_tick` pulses set by `rate_sel`: 01 gives 1, 10 gives 16, 11 gives 64, and 00 behaves like 01. Cycles without a tick do not advance the frame.
- R6: `stop_sel` sets the stop interval. 01 gives one bit time. 11 gives two bit times. 10 gives 1.5 bit times, which is 24 ticks at rate 10 and 96 ticks at rate 11; at rate 01 or 00 it gives 2 ticks. 00 gives one bit time.
- R7: A pulse on `ld` while `ready` is high stores `ld_data`, and `ready` is low in the following cycle. A pulse on `ld` while `ready` is low is ignored, and the stored character is unchanged.
- R8: `ready` rises again once the buffered character has moved into the shifter, which is while its start bit is on the line. A second character loaded then follows straight after the first frame's stop interval.
- R9: `empty` is low from the cycle after a character is accepted until that character's stop interval has ended. It is high afterwards when no further character is buffered.
- R10: A buffered character starts only while `tx_en` and `cts` are both high. Dropping either one during a frame does not shorten or alter that frame.
- R11: While `brk` is high, `txd` is low in the same cycle whatever the shifter is doing. After `brk` is released, `txd` again follows the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_tick | input | 1 | Bit-timing clock enable (1, 16 or 64 per bit) |
| rate_sel | input | 2 | Ticks per bit: 01 x1, 10 x16, 11 x64, 00 as x1 |
| len_sel | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| stop_sel | input | 2 | Stop interval: 01 one, 10 one and a half, 11 two, 00 one |
| tx_en | input | 1 | Transmit enable |
| cts | input | 1 | Clear to send, active high |
| brk | input | 1 | Force the line low |
| ld | input | 1 | Load strobe for the holding buffer |
| ld_data | input | 8 | Character to load |
| txd | output | 1 | Serial line |
| ready | output | 1 | Holding buffer can accept a character |
| empty | output | 1 | Nothing buffered and nothing being shifted |

## Verification
A wrong phase or bit index inside the shifter shows on `txd` as a level mismatch at some tick within the frame that contains it. The bench compares every tick-sampled level of every frame, so such an error is caught in the first frame it affects. A miscounted tick counter stretches or shortens one bit. Because the frame is sampled end to end, the error moves every later bit out of place and shows up before that frame ends. Errors in the holding buffer or the transfer condition show up as `ready` or `empty` at a wrong value within a cycle or two of a load, or as the wrong character, or no character at all, leaving the line.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    // Parity bit over the low (5 + len) bits; even = 1 gives even total parity.
    function automatic logic par_of(input logic [DATA_W-1:0] d,
                                    input logic [1:0]        len,
                                    input logic              even);
        logic p;
        p = ~even;
        for (int i = 0; i < int'(DATA_W); i++) begin
            if (i < 5 + int'(len)) p = p ^ d[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.full = 1'b0;
        end else if (ld && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign data = st_q.data;

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !take) |=> (st_q.full && $stable(st_q.data)));

    // R8
    take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !st_q.full);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int unsigned MID_DIV = 16,
    parameter int unsigned HI_DIV  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        rate_sel,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              par_even,
    input  logic [1:0]        stop_sel,
    input  logic              take,
    input  logic [DATA_W-1:0] take_data,
    output logic              idle,
    output logic              line
);

    localparam int unsigned CW = $clog2(2 * HI_DIV);
    localparam int unsigned LW = CW + 1;
    localparam int unsigned BW = $clog2(DATA_W);

    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] sh;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     bidx;
        logic              par;
        logic              line;
    } shift_t;

    shift_t st_d, st_q;

    logic [LW-1:0] bit_len, stop_len, cur_len;
    logic [BW-1:0] last_bit;
    logic          done;

    always_comb begin
        case (rate_sel)
            2'b10:   bit_len = LW'(MID_DIV);
            2'b11:   bit_len = LW'(HI_DIV);
            default: bit_len = LW'(1);
        endcase
        case (stop_sel)
            2'b10:   stop_len = (bit_len == LW'(1)) ? LW'(2) : bit_len + (bit_len >> 1);
            2'b11:   stop_len = bit_len << 1;
            default: stop_len = bit_len;
        endcase
        cur_len  = (st_q.phase == PH_STOP) ? stop_len : bit_len;
        done     = tick && ({1'b0, st_q.cnt} == cur_len - 1'b1);
        last_bit = BW'(4) + BW'(len_sel);
    end

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PH_IDLE) begin
            st_d.line = 1'b1;
            st_d.cnt  = '0;
            if (take) begin
                st_d.phase = PH_START;
                st_d.sh    = take_data;
                st_d.par   = par_of(take_data, len_sel, par_even);
                st_d.line  = 1'b0;
            end
        end else if (tick) begin
            st_d.cnt = done ? '0 : st_q.cnt + 1'b1;
            if (done) begin
                case (st_q.phase)
                    PH_START: begin
                        st_d.phase = PH_DATA;
                        st_d.bidx  = '0;
                        st_d.line  = st_q.sh[0];
                    end
                    PH_DATA: begin
                        if (st_q.bidx == last_bit) begin
                            st_d.phase = par_en ? PH_PAR : PH_STOP;
                            st_d.line  = par_en ? st_q.par : 1'b1;
                        end else begin
                            st_d.bidx = st_q.bidx + 1'b1;
                            st_d.sh   = st_q.sh >> 1;
                            st_d.line = st_q.sh[1];
                        end
                    end
                    PH_PAR: begin
                        st_d.phase = PH_STOP;
                        st_d.line  = 1'b1;
                    end
                    default: begin
                        st_d.phase = PH_IDLE;
                        st_d.line  = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.line  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle = (st_q.phase == PH_IDLE);
    assign line = st_q.line;

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE) |-> st_q.line);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_START) |-> !st_q.line);

    // R6
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_STOP) |-> st_q.line);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE) |-> ({1'b0, st_q.cnt} < cur_len));

    // R5
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && !tick) |=> ($stable(st_q.cnt) && $stable(st_q.line)));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned MID_DIV = 16,
    parameter int unsigned HI_DIV  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_tick,
    input  logic [1:0]        rate_sel,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              par_even,
    input  logic [1:0]        stop_sel,
    input  logic              tx_en,
    input  logic              cts,
    input  logic              brk,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_data,
    output logic              txd,
    output logic              ready,
    output logic              empty
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              shift_idle;
    logic              shift_line;
    logic              take;

    assign take = shift_idle && hold_full && tx_en && cts;

    sertx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (ld),
        .ld_data (ld_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_shift #(
        .MID_DIV (MID_DIV),
        .HI_DIV  (HI_DIV)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tx_tick),
        .rate_sel  (rate_sel),
        .len_sel   (len_sel),
        .par_en    (par_en),
        .par_even  (par_even),
        .stop_sel  (stop_sel),
        .take      (take),
        .take_data (hold_data),
        .idle      (shift_idle),
        .line      (shift_line)
    );

    assign txd   = brk ? 1'b0 : shift_line;
    assign ready = !hold_full;
    assign empty = !hold_full && shift_idle;

    // R10
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_idle) |-> $past(tx_en && cts));

    // R9
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> ready);

    // R11
    brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);

endmodule

// File: tb/sertx_top_bench.sv
`timescale 1ns/1ps
module sertx_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] rate_sel = 2'b01, len_sel = 2'b11, stop_sel = 2'b01;
    logic       par_en = 1'b0, par_even = 1'b0;
    logic       tx_en = 1'b1, cts = 1'b1, brk = 1'b0, ld = 1'b0;
    logic [7:0] ld_data = '0;
    logic       txd, ready, empty;

    int nchk = 0, nfail = 0, tdiv = 1, tph = 0;
    bit finished = 0;

    sertx_top u_sertx_top (
        .clk(clk), .rst_n(rst_n), .tx_tick(tick), .rate_sel(rate_sel),
        .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
        .stop_sel(stop_sel), .tx_en(tx_en), .cts(cts), .brk(brk),
        .ld(ld), .ld_data(ld_data), .txd(txd), .ready(ready), .empty(empty)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (tph + 1 >= tdiv) begin tph <= 0; tick <= 1'b1; end
        else begin tph <= tph + 1; tick <= 1'b0; end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] v);
        @(negedge clk); ld_data = v; ld = 1'b1;
        @(negedge clk); ld = 1'b0;
    endtask

    // Records txd at every tick from the start bit on and compares the whole frame.
    task automatic grab(input logic [7:0] v, input string tag);
        int L, S, n, E, w, k, idx, fk;
        bit bad;
        logic ex, fa, fe, pb;
        case (rate_sel) 2'b10: L = 16; 2'b11: L = 64; default: L = 1; endcase
        case (stop_sel)
            2'b10:   S = (L == 1) ? 2 : L * 3 / 2;
            2'b11:   S = 2 * L;
            default: S = L;
        endcase
        n = 5 + int'(len_sel);
        pb = ~par_even;
        for (int i = 0; i < n; i++) pb = pb ^ v[i];
        E = L * (1 + n + (par_en ? 1 : 0)) + S;
        w = 0;
        while (txd !== 1'b0 && w < 5000) begin @(negedge clk); w++; end
        chk(w < 5000, {tag, " start seen"}, w, 0);
        k = 0; bad = 0; fk = 0; fa = 0; fe = 0;
        while (k < E) begin
            if (tick) begin
                idx = k / L;
                if (idx == 0) ex = 1'b0;
                else if (idx <= n) ex = v[idx-1];
                else if (par_en && idx == n + 1) ex = pb;
                else ex = 1'b1;
                if (txd !== ex && !bad) begin bad = 1; fk = k; fa = txd; fe = ex; end
                k++;
            end
            @(negedge clk);
        end
        chk(!bad, {tag, " frame"}, {fk, 4'(fa)}, {fk, 4'(fe)});
        chk(txd === 1'b1, {tag, " line high after stop"}, txd, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int seq = 0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(txd === 1 && ready === 1 && empty === 1, "R1 in reset", {txd, ready, empty}, 3'b111);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(txd === 1 && ready === 1 && empty === 1, "R1 after reset", {txd, ready, empty}, 3'b111);

        // R2 R3 R4 R5 R6 R9: sweep of rate, length, parity and stop codes
        for (int r = 1; r < 4; r++) begin
            tdiv = (r == 1) ? 3 : ((r == 2) ? 2 : 1);
            for (int ln = 0; ln < 4; ln++)
                for (int pm = 0; pm < 3; pm++)
                    for (int st = 0; st < 4; st++) begin
                        @(negedge clk);
                        rate_sel = 2'(r); len_sel = 2'(ln); stop_sel = 2'(st);
                        par_en = (pm != 0); par_even = (pm == 2);
                        seq++;
                        put(8'(8'h5A + 13 * seq));
                        grab(8'(8'h5A + 13 * seq), "R2 R3 R4 R5 R6 sweep");
                        @(negedge clk);
                        chk(empty === 1 && ready === 1, "R9 empty after frame", {empty, ready}, 2'b11);
                    end
        end

        // R5: rate code 00 behaves as x1; R4 exhaustive byte sweep at 8 bits, even parity
        tdiv = 1; rate_sel = 2'b00; len_sel = 2'b11; par_en = 1; par_even = 1; stop_sel = 2'b01;
        put(8'hC3); grab(8'hC3, "R5 rate 00");
        rate_sel = 2'b01;
        for (int v = 0; v < 256; v++) begin
            put(8'(v)); grab(8'(v), "R4 byte sweep");
        end

        // R7 R10: buffer held while gated; second load ignored
        rate_sel = 2'b10; tdiv = 1; par_en = 0; stop_sel = 2'b01;
        @(negedge clk); tx_en = 0;
        put(8'h96);
        chk(ready === 0 && empty === 0, "R7 accepted load", {ready, empty}, 2'b00);
        put(8'h3C);
        repeat (40) @(negedge clk);
        chk(txd === 1, "R10 no start with tx_en low", txd, 1);
        tx_en = 1; cts = 0;
        repeat (40) @(negedge clk);
        chk(txd === 1 && ready === 0, "R10 no start with cts low", {txd, ready}, 2'b10);
        cts = 1;
        grab(8'h96, "R7 first character kept");
        @(negedge clk);
        chk(empty === 1, "R7 ignored load left nothing", empty, 1);

        // R10: dropping the gates mid-frame does not cut the frame
        fork
            grab(8'hE1, "R10 frame completes");
            begin
                put(8'hE1);
                repeat (60) @(negedge clk);
                tx_en = 0; cts = 0;
            end
        join
        tx_en = 1; cts = 1;

        // R8 R9: ready back during start bit, back-to-back frames
        fork
            grab(8'h4D, "R8 first of pair");
            begin
                put(8'h4D);
                while (txd !== 1'b0) @(negedge clk);
                chk(ready === 1 && empty === 0, "R8 ready during start bit", {ready, empty}, 2'b10);
                put(8'hB2);
                chk(ready === 0, "R7 ready low after second load", ready, 0);
            end
        join
        chk(empty === 0, "R9 empty low with second pending", empty, 0);
        grab(8'hB2, "R8 second of pair");
        @(negedge clk);
        chk(empty === 1, "R9 empty after pair", empty, 1);

        // R11: break in idle and during a frame
        @(negedge clk); brk = 1; #1;
        chk(txd === 0, "R11 break in idle", txd, 0);
        @(negedge clk); brk = 0; #1;
        chk(txd === 1, "R11 release in idle", txd, 1);
        put(8'hFF);
        repeat (40) @(negedge clk);
        brk = 1; #1;
        chk(txd === 0, "R11 break during frame", txd, 0);
        @(negedge clk); brk = 0;
        repeat (400) @(negedge clk);
        chk(txd === 1 && empty === 1, "R11 line returns after break", {txd, empty}, 2'b11);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule